// File: doc/BRIEF.md
# Shadowed Control and Interrupt Register Block

This block is the register file of a display timing controller. Software writes through a single-cycle word port. Every configuration word, including the start-control word, lands first in a shadow copy. The timing generator sees only the active copies. A write of 1 to bit 0 of the load register moves the whole shadow set into the active set on one clock edge, so a sequence of writes can never reach the timing logic half finished.

One interrupt word holds three things for four timing events: the sticky event flags, the mask bits and the write-one-to-clear controls. The interrupt output is raised while any flag is set whose mask bit is 0. Software can also poll the display-end flag to learn that the previous update has finished.

Bit 0 of the start-control word begins a frame sequence. When a load takes the active copy of this bit from 0 to 1, the timing generator receives a pulse one cycle wide. To begin a new sequence, software must therefore load the bit as 0 before it loads it as 1.

Top module: `dtc_shadow_regs`

## Requirements
- R1: After reset, all shadow and active words are 0, the interrupt word reads 0, and `irq` and `frame_go` are low.
- R2: A write to a configuration word (start word at address 0, config words at addresses 1..NUM_CFG) changes that word's read value at the next clock. It leaves every active output unchanged.
- R3: A write to the load address (NUM_CFG+2) with data bit 0 set copies every shadow word into its active output on that clock edge. With data bit 0 clear, nothing changes. The load address reads 0.
- R4: In the interrupt word (address NUM_CFG+1), event input bit i sets flag bit i: bit 0 frame end, bit 1 display end, bit 2 frame interrupt, bit 3 line flag. A flag stays set until it is cleared.
- R5: Interrupt-word bits 4..7 are the mask bits for the same four events in the same order, and read back as written. `irq` is high exactly when some flag is set whose mask bit is 0.
- R6: Writing 1 to interrupt-word bit 8+i clears flag i. A clear bit written as 0 leaves its flag alone. Bits 8..11 always read 0.
- R7: When an event and the clear of the same flag arrive in one cycle, the flag stays set.
- R8: `frame_go` is high for exactly one cycle, the cycle after a load that takes active start bit 0 from 0 to 1. A load that leaves that bit at 1 produces no pulse.
- R9: The flag bits 0..3 of a write to the interrupt word are ignored. Flags change only through events and clear bits.
- R10: A write to any address above NUM_CFG+2 changes nothing, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| evt_in | input | 4 | Event pulses from the timing generator |
| act_start | output | DATA_W | Active start-control word |
| act_cfg | output | NUM_CFG*DATA_W | Active config words, word 0 in the low bits |
| frame_go | output | 1 | One-cycle frame-start pulse |
| irq | output | 1 | Interrupt request |

## Verification
A shadow word that has been corrupted stays hidden until the next load. It then shows on an active output on that edge, so every load is followed by a comparison of all active words. A load strobe that fires by mistake shows at once as an active word moving without a load write. A flag that sets or clears wrongly shows on `irq` and in the interrupt read one cycle after the event. A start-edge detector that latches a stale value shows as a missing or extra `frame_go` in the cycle after the load.

// File: rtl/dtc_regs_pkg.sv
package dtc_regs_pkg;
  localparam int EV_N   = 4;
  localparam int ST_LSB = 0;
  localparam int MK_LSB = 4;
  localparam int CL_LSB = 8;
  localparam int INT_W  = 12;

  // next flag state: a new event dominates a same-cycle clear
  function automatic logic [EV_N-1:0] flag_next(input logic [EV_N-1:0] cur,
                                                input logic [EV_N-1:0] ev,
                                                input logic [EV_N-1:0] clr);
    return ev | (cur & ~clr);
  endfunction

  function automatic logic irq_of(input logic [EV_N-1:0] st,
                                  input logic [EV_N-1:0] mk);
    return |(st & ~mk);
  endfunction

  // read view of the interrupt word: clear bits always read 0
  function automatic logic [INT_W-1:0] int_view(input logic [EV_N-1:0] st,
                                                input logic [EV_N-1:0] mk);
    return {{EV_N{1'b0}}, mk, st};
  endfunction
endpackage

// File: rtl/dtc_shadow_bank.sv
module dtc_shadow_bank #(
  parameter int DATA_W = 32,
  parameter int N_REGS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REGS-1:0] we,
  input  logic [DATA_W-1:0] wd,
  input  logic              load,
  output logic [DATA_W-1:0] sh  [N_REGS],
  output logic [DATA_W-1:0] act [N_REGS]
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh[g]  <= '0;
        act[g] <= '0;
      end else begin
        if (we[g]) sh[g]  <= wd;
        if (load)  act[g] <= sh[g];
      end
    end
  end
endmodule

// File: rtl/dtc_irq_unit.sv
module dtc_irq_unit
  import dtc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_we,
  input  logic [INT_W-1:0] wd,
  input  logic [EV_N-1:0]  ev,
  output logic [EV_N-1:0]  clr,
  output logic [EV_N-1:0]  st,
  output logic [EV_N-1:0]  mk,
  output logic             irq
);
  logic [EV_N-1:0] wd_flags_unused;
  assign wd_flags_unused = wd[ST_LSB +: EV_N];
  assign clr = int_we ? wd[CL_LSB +: EV_N] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
      mk <= '0;
    end else begin
      st <= flag_next(st, ev, clr);
      if (int_we) mk <= wd[MK_LSB +: EV_N];
    end
  end

  assign irq = irq_of(st, mk);
endmodule

// File: rtl/dtc_start_edge.sv
module dtc_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sh_bit,
  input  logic act_bit,
  output logic go
);
  // the pulse is registered on the load edge, so it lines up with the active change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go <= 1'b0;
    else        go <= load & sh_bit & ~act_bit;
  end
endmodule

// File: rtl/dtc_shadow_regs.sv
module dtc_shadow_regs
  import dtc_regs_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NUM_CFG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [EV_N-1:0]           evt_in,
  output logic [DATA_W-1:0]         act_start,
  output logic [NUM_CFG*DATA_W-1:0] act_cfg,
  output logic                      frame_go,
  output logic                      irq
);
  localparam int N_REGS = NUM_CFG + 1;
  localparam int INT_A  = NUM_CFG + 1;
  localparam int DONE_A = NUM_CFG + 2;
  localparam int FLAT_W = N_REGS * DATA_W;

  logic [N_REGS-1:0] we_vec;
  logic              load_stb;
  logic              int_we;
  logic [DATA_W-1:0] sh  [N_REGS];
  logic [DATA_W-1:0] act [N_REGS];
  logic [FLAT_W-1:0] sh_flat;
  logic [FLAT_W-1:0] act_flat;
  logic [EV_N-1:0]   flag_q, mask_q, clr_vec;

  always_comb begin
    for (int i = 0; i < N_REGS; i++)
      we_vec[i] = wr_en && (wr_addr == ADDR_W'(i));
  end
  assign load_stb = wr_en && (wr_addr == ADDR_W'(DONE_A)) && wr_data[0];
  assign int_we   = wr_en && (wr_addr == ADDR_W'(INT_A));

  dtc_shadow_bank #(.DATA_W(DATA_W), .N_REGS(N_REGS)) bank_i (
    .clk(clk), .rst_n(rst_n), .we(we_vec), .wd(wr_data),
    .load(load_stb), .sh(sh), .act(act)
  );

  dtc_irq_unit irq_i (
    .clk(clk), .rst_n(rst_n), .int_we(int_we), .wd(wr_data[INT_W-1:0]),
    .ev(evt_in), .clr(clr_vec), .st(flag_q), .mk(mask_q), .irq(irq)
  );

  dtc_start_edge edge_i (
    .clk(clk), .rst_n(rst_n), .load(load_stb),
    .sh_bit(sh[0][0]), .act_bit(act[0][0]), .go(frame_go)
  );

  for (genvar g = 0; g < N_REGS; g++) begin : g_flat
    assign sh_flat[g*DATA_W +: DATA_W]  = sh[g];
    assign act_flat[g*DATA_W +: DATA_W] = act[g];
  end

  assign act_start = act[0];
  assign act_cfg   = act_flat[FLAT_W-1:DATA_W];

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = sh[i];
    if (rd_addr == ADDR_W'(INT_A))
      rd_data = DATA_W'(int_view(flag_q, mask_q));
  end
endmodule

// File: rtl/dtc_shadow_regs_chk.sv
module dtc_shadow_regs_chk #(
  parameter int FLAT_W = 160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [FLAT_W-1:0] sh_flat,
  input logic [FLAT_W-1:0] act_flat,
  input logic [3:0]        ev,
  input logic [3:0]        clr,
  input logic [3:0]        flags,
  input logic              go,
  input logic              start_bit,
  input logic              irq
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_flat));
  assert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_flat == $past(sh_flat)));
  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flags & $past(ev)) == $past(ev)));
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~clr)) |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));
  assert_noset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == 4'b0) |=> ((flags & ~$past(flags)) == 4'b0));
  assert_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (start_bit && $past(load)));
  assert_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 4'b0));
endmodule

bind dtc_shadow_regs dtc_shadow_regs_chk #(.FLAT_W(FLAT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load_stb), .sh_flat(sh_flat),
  .act_flat(act_flat), .ev(evt_in), .clr(clr_vec), .flags(flag_q),
  .go(frame_go), .start_bit(act_start[0]), .irq(irq)
);

// File: tb/dtc_shadow_regs_tb_top.sv
`timescale 1ns/1ps
module dtc_shadow_regs_tb_top;
  localparam int AW = 4, DW = 32, NC = 4;
  localparam int INT_A = NC + 1, DONE_A = NC + 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [3:0] evt_in = '0;
  logic [DW-1:0] act_start;
  logic [NC*DW-1:0] act_cfg;
  logic frame_go, irq;
  int errors = 0, checks = 0;
  logic [DW-1:0] pat [NC+1];

  always #2 clk = ~clk;

  dtc_shadow_regs #(.ADDR_W(AW), .DATA_W(DW), .NUM_CFG(NC)) dut_i (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, int a, logic [DW-1:0] exp);
    rd_addr = AW'(a); #1; chk(req, rd_data, exp);
  endtask

  task automatic pulse_ev(logic [3:0] e);
    @(negedge clk); evt_in = e;
    @(negedge clk); evt_in = '0;
  endtask

  function automatic logic [DW-1:0] act_word(int i);
    return (i == 0) ? act_start : act_cfg[(i-1)*DW +: DW];
  endfunction

  task automatic chk_act(string req, logic all_zero);
    for (int i = 0; i <= NC; i++) chk(req, act_word(i), all_zero ? '0 : pat[i]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) rd("R1", a, '0);
    chk_act("R1", 1);
    chk("R1", {31'b0, irq}, '0);
    chk("R1", {31'b0, frame_go}, '0);

    // R2 shadow writes are invisible until load
    for (int i = 0; i <= NC; i++) begin
      pat[i] = 32'hC3A50000 ^ (32'h01010110 * (i + 1));
      wr(i, pat[i]);
      rd("R2", i, pat[i]);
    end
    chk_act("R2", 1);

    // R3 load with bit0 clear does nothing; set copies all
    wr(DONE_A, 32'hFFFF_FFFE);
    chk_act("R3", 1);
    wr(DONE_A, 32'h1);
    chk_act("R3", 0);
    rd("R3", DONE_A, '0);
    chk("R8", {31'b0, frame_go}, '0);  // start bit0 was 0 in pat[0]

    // R8 start pulse on 0->1 of active bit 0
    wr(0, pat[0] | 32'h1);
    chk("R2", act_start, pat[0]);
    wr(DONE_A, 32'h1);
    chk("R8", {31'b0, frame_go}, 32'h1);
    @(negedge clk);
    chk("R8", {31'b0, frame_go}, '0);
    wr(DONE_A, 32'h1);
    chk("R8", {31'b0, frame_go}, '0);
    wr(0, pat[0]); wr(DONE_A, 32'h1);
    chk("R8", {31'b0, frame_go}, '0);
    wr(0, pat[0] | 32'h1); wr(DONE_A, 32'h1);
    chk("R8", {31'b0, frame_go}, 32'h1);

    // R4/R5 sweep every event against every mask
    for (int e = 0; e < 4; e++) begin
      for (int m = 0; m < 16; m++) begin
        wr(INT_A, {20'b0, 4'hF, 4'(m), 4'h0});
        rd("R6", INT_A, {20'b0, 4'h0, 4'(m), 4'h0});
        pulse_ev(4'(1 << e));
        @(negedge clk);
        rd("R4", INT_A, {20'b0, 4'h0, 4'(m), 4'(1 << e)});
        chk("R5", {31'b0, irq}, {31'b0, ~m[e]});
      end
    end

    // R6 selective clear
    for (int j = 0; j < 4; j++) begin
      wr(INT_A, {20'b0, 4'hF, 4'hF, 4'h0});
      pulse_ev(4'hF);
      wr(INT_A, {20'b0, 4'(1 << j), 4'hF, 4'h0});
      rd("R6", INT_A, {20'b0, 4'h0, 4'hF, 4'hF & ~4'(1 << j)});
      chk("R5", {31'b0, irq}, '0);
    end

    // R7 event beats a same-cycle clear
    wr(INT_A, {20'b0, 4'hF, 4'h0, 4'h0});
    @(negedge clk); wr_en = 1; wr_addr = AW'(INT_A); wr_data = {20'b0, 4'h2, 4'h0, 4'h0}; evt_in = 4'h2;
    @(negedge clk); wr_en = 0; evt_in = 4'h0;
    rd("R7", INT_A, 32'h2);
    chk("R7", {31'b0, irq}, 32'h1);

    // R9 flag bits in write data are ignored
    wr(INT_A, {20'b0, 4'hF, 4'h0, 4'h0});
    wr(INT_A, {20'b0, 4'h0, 4'h0, 4'hF});
    rd("R9", INT_A, '0);
    chk("R9", {31'b0, irq}, '0);

    // R10 unused addresses
    for (int a = DONE_A + 1; a < 16; a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd("R10", a, '0);
    end
    pat[0] = pat[0] | 32'h1;
    chk_act("R10", 0);
    for (int i = 0; i <= NC; i++) rd("R10", i, pat[i]);
    rd("R10", INT_A, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule